// File: doc/BRIEF.md
# Servo Reference Square-Wave Generator

This block produces the square-wave reference that times the drum and capstan phase loops of a tape servo. A half-period down-counter toggles the output on expiry, giving a 50% duty wave whose period is twice the programmed half-period. In playback the wave either runs freely from the counter or toggles on an external trigger input. In record the wave is resynchronised by each accepted vertical-sync (VD) pulse. If a pulse goes missing, the counter toggles the output anyway.

An 8-bit control register selects the timing source. It is written through a synchronous write-enable port. Its fields choose:
- external sync in playback,
- automatic (noise-flag driven) or software choice between VD-locked and free-run timing in record,
- frame alignment of the output phase to the odd/even field flag.

A change from playback to record forces the output low. An upstream block supplies a VD mask; masked pulses are ignored.

The generator is a five-state machine. Each cycle, a combinational selector picks the operating state from the inputs and the control register, and the core acts on that state:
- **ST_IDLE**: half-period is zero.
- **ST_PB_FREE**: playback, free-run.
- **ST_PB_EXT**: playback, external trigger.
- **ST_REC_VD**: record, VD-locked.
- **ST_REC_FREE**: record, free-run.

Transitions:
- Any state goes to ST_IDLE when the half-period becomes zero.
- ST_IDLE goes to ST_PB_* or ST_REC_* when the half-period becomes non-zero.
- ST_PB_FREE and ST_PB_EXT switch between each other on control bit 4.
- ST_REC_VD and ST_REC_FREE switch between each other on the record select.
- ST_PB_FREE or ST_PB_EXT going to ST_REC_VD or ST_REC_FREE is the playback-to-record transition, which clears the output.

Top module: `servo_ref_gen`

## Requirements
- R1: While reset is asserted `ref_out` is 0 and the control register is 0.
- R2: In free-run timing with half-period H>0, the counter is loaded with H and `ref_out` toggles every H cycles, giving a period of 2H with 50% duty. In free-run, VD and trigger inputs have no effect.
- R3: In playback with control bit 4 = 1, `ref_out` toggles in the cycle after each `ext_trig` pulse and holds otherwise.
- R4: In VD-locked record timing, an accepted VD pulse toggles `ref_out` in the next cycle and reloads the counter with H.
- R5: In VD-locked record timing, if no VD pulse is accepted for H cycles after the last reload, the counter expiry toggles `ref_out`, filling in the missing pulse.
- R6: A VD pulse arriving while `vd_mask` is 1 is ignored.
- R7: Record timing source selection:
  - With control bit 6 = 1, VD-locked timing is used while `vnoise` = 0 and free-run while `vnoise` = 1.
  - With bit 6 = 0, control bit 5 = 1 selects VD-locked and bit 5 = 0 selects free-run.
- R8: On a change from a playback state to a record state, `ref_out` is forced to 0 and the counter is reloaded with H.
- R9: With control bit 3 = 1 (frame alignment), an accepted VD pulse sets `ref_out` to 1 when `field` equals control bit 2 and to 0 otherwise, instead of toggling.
- R10: A half-period of 0 holds `ref_out` at 0 and stops the counter. When the half-period becomes non-zero, the first cycle loads the counter without toggling.
- R11: `cfg_we` = 1 stores `cfg_wdata` at the clock edge, and the new value applies from the following cycle. A half-period change takes effect at the next counter reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_period | input | CNT_W | Half-period in clock cycles; 0 stops the generator |
| rec_mode | input | 1 | 1 = record, 0 = playback |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data (bit 2 field select, 3 frame enable, 4 external sync, 5 software VD select, 6 automatic select) |
| vd_pulse | input | 1 | Vertical-sync pulse, one cycle wide |
| vd_mask | input | 1 | 1 = ignore VD this cycle |
| vnoise | input | 1 | Vertical noise detected flag |
| field | input | 1 | Current field flag (odd/even) |
| ext_trig | input | 1 | External trigger pulse, one cycle wide |
| ref_out | output | 1 | Reference square wave |

## Verification
The free-run counter is run at two half-periods, with one change made mid-cycle to show the new value only lands at reload. Trigger pulses at uneven gaps separate external-sync toggling from counter toggling. Record mode is driven three ways: with VD pulses shorter than the half-period, with a long VD gap, and with masked pulses. Together these separate VD resync from counter fill-in and from ignored input. Noise flag sweeps under automatic select, field patterns under frame alignment, and repeated playback-to-record changes and zero half-periods cover the phase-forcing paths.

// File: rtl/srg_pkg.sv
package srg_pkg;
    localparam int CFG_W = 8;
    localparam int BIT_FSEL  = 2;
    localparam int BIT_FRAME = 3;
    localparam int BIT_EXT   = 4;
    localparam int BIT_SWVD  = 5;
    localparam int BIT_AUTO  = 6;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PB_FREE,
        ST_PB_EXT,
        ST_REC_VD,
        ST_REC_FREE
    } srg_state_e;

    typedef struct packed {
        logic auto_sel;
        logic sw_vd;
        logic ext_sync;
        logic frame_en;
        logic field_sel;
    } srg_cfg_t;
endpackage

// File: rtl/srg_cfg_reg.sv
module srg_cfg_reg
    import srg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output srg_cfg_t         cfg
);
    logic [CFG_W-1:0] reg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      reg_q <= '0;
        else if (cfg_we) reg_q <= cfg_wdata;
    end

    assign cfg.auto_sel  = reg_q[BIT_AUTO];
    assign cfg.sw_vd     = reg_q[BIT_SWVD];
    assign cfg.ext_sync  = reg_q[BIT_EXT];
    assign cfg.frame_en  = reg_q[BIT_FRAME];
    assign cfg.field_sel = reg_q[BIT_FSEL];

    logic unused_bits;
    assign unused_bits = ^{reg_q[CFG_W-1], reg_q[1:0]};

    assert_cfg_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_q == '0) || $past(cfg_we));
endmodule

// File: rtl/srg_src_sel.sv
module srg_src_sel
    import srg_pkg::*;
(
    input  srg_cfg_t   cfg,
    input  logic       rec_mode,
    input  logic       half_zero,
    input  logic       vnoise,
    output srg_state_e src
);
    logic want_vd;

    always_comb begin
        want_vd = cfg.auto_sel ? ~vnoise : cfg.sw_vd;
        if (half_zero)     src = ST_IDLE;
        else if (!rec_mode) src = cfg.ext_sync ? ST_PB_EXT : ST_PB_FREE;
        else               src = want_vd ? ST_REC_VD : ST_REC_FREE;
    end
endmodule

// File: rtl/srg_core.sv
module srg_core
    import srg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  srg_state_e       src,
    input  srg_cfg_t         cfg,
    input  logic [CNT_W-1:0] half_period,
    input  logic             vd_pulse,
    input  logic             vd_mask,
    input  logic             field,
    input  logic             ext_trig,
    output logic             ref_out
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    srg_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] tick_cnt;
    logic             tick_out;
    logic             pb2rec;
    logic             vd_ok;
    logic             src_pb, src_rec, state_pb;

    assign src_pb   = (src == ST_PB_FREE) || (src == ST_PB_EXT);
    assign src_rec  = (src == ST_REC_VD) || (src == ST_REC_FREE);
    assign state_pb = (state == ST_PB_FREE) || (state == ST_PB_EXT);
    assign pb2rec   = state_pb && src_rec;
    assign vd_ok    = vd_pulse && !vd_mask;

    // counter step shared by free-run and VD fill-in
    always_comb begin
        tick_out = ref_out;
        if (cnt == '0) begin
            tick_cnt = half_period;
        end else if (cnt == ONE) begin
            tick_cnt = half_period;
            tick_out = ~ref_out;
        end else begin
            tick_cnt = cnt - ONE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= src;
    end

    // output and counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_out <= 1'b0;
            cnt     <= '0;
        end else if (pb2rec) begin
            ref_out <= 1'b0;
            cnt     <= half_period;
        end else begin
            unique case (src)
                ST_IDLE: begin
                    ref_out <= 1'b0;
                    cnt     <= '0;
                end
                ST_PB_EXT: begin
                    if (ext_trig) ref_out <= ~ref_out;
                    cnt <= half_period;
                end
                ST_REC_VD: begin
                    if (vd_ok) begin
                        ref_out <= cfg.frame_en ? (field == cfg.field_sel) : ~ref_out;
                        cnt     <= half_period;
                    end else begin
                        ref_out <= tick_out;
                        cnt     <= tick_cnt;
                    end
                end
                ST_PB_FREE, ST_REC_FREE: begin
                    ref_out <= tick_out;
                    cnt     <= tick_cnt;
                end
                default: begin
                    ref_out <= 1'b0;
                    cnt     <= '0;
                end
            endcase
        end
    end

    assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ST_IDLE) |=> (!ref_out && cnt == '0));
    assert_pb2rec_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pb2rec |=> !ref_out);
    assert_ext_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ST_PB_EXT && !ext_trig) |=> $stable(ref_out));
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ST_REC_VD && !pb2rec && vd_pulse && vd_mask && cnt > ONE) |=> $stable(ref_out));
    assert_free_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((src == ST_PB_FREE || src == ST_REC_FREE) && !pb2rec && cnt > ONE) |=> $stable(ref_out));
    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (src == ST_REC_VD && !pb2rec && vd_ok) |=> (cnt == $past(half_period)));

    logic unused_pb;
    assign unused_pb = src_pb;
endmodule

// File: rtl/servo_ref_gen.sv
module servo_ref_gen
    import srg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] half_period,
    input  logic             rec_mode,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic             vd_pulse,
    input  logic             vd_mask,
    input  logic             vnoise,
    input  logic             field,
    input  logic             ext_trig,
    output logic             ref_out
);
    srg_cfg_t   cfg;
    srg_state_e src;

    srg_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg)
    );

    srg_src_sel u_sel (
        .cfg       (cfg),
        .rec_mode  (rec_mode),
        .half_zero (half_period == '0),
        .vnoise    (vnoise),
        .src       (src)
    );

    srg_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (src),
        .cfg         (cfg),
        .half_period (half_period),
        .vd_pulse    (vd_pulse),
        .vd_mask     (vd_mask),
        .field       (field),
        .ext_trig    (ext_trig),
        .ref_out     (ref_out)
    );
endmodule

// File: tb/tb_servo_ref_gen.sv
module tb_servo_ref_gen;
    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] half_period = '0;
    logic             rec_mode = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_wdata = '0;
    logic             vd_pulse = 1'b0;
    logic             vd_mask = 1'b0;
    logic             vnoise = 1'b0;
    logic             field = 1'b0;
    logic             ext_trig = 1'b0;
    logic             ref_out;

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    servo_ref_gen #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .half_period(half_period), .rec_mode(rec_mode),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .vd_pulse(vd_pulse), .vd_mask(vd_mask),
        .vnoise(vnoise), .field(field), .ext_trig(ext_trig), .ref_out(ref_out)
    );

    // behavioural reference: kind 0 idle, 1 pb free, 2 pb ext, 3 rec vd, 4 rec free
    int        m_cnt = 0;
    bit        m_out = 0;
    int        m_prev = 0;
    bit [7:0]  m_cfg = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_out = 0; m_prev = 0; m_cfg = 0;
        end else begin
            int  kind;
            bit  use_vd;
            int  h;
            h = int'(half_period);
            use_vd = m_cfg[6] ? !vnoise : m_cfg[5];
            if (h == 0)        kind = 0;
            else if (!rec_mode) kind = m_cfg[4] ? 2 : 1;
            else               kind = use_vd ? 3 : 4;
            if ((m_prev == 1 || m_prev == 2) && kind >= 3) begin
                m_out = 0; m_cnt = h;
            end else if (kind == 0) begin
                m_out = 0; m_cnt = 0;
            end else if (kind == 2) begin
                if (ext_trig) m_out = !m_out;
                m_cnt = h;
            end else if (kind == 3 && vd_pulse && !vd_mask) begin
                if (m_cfg[3]) m_out = (field == m_cfg[2]);
                else          m_out = !m_out;
                m_cnt = h;
            end else begin
                if (m_cnt == 0) m_cnt = h;
                else if (m_cnt == 1) begin m_out = !m_out; m_cnt = h; end
                else m_cnt = m_cnt - 1;
            end
            m_prev = kind;
            if (cfg_we) m_cfg = cfg_wdata;
        end
    end

    always @(negedge clk) begin
        total++;
        if (!rst_n) begin
            if (ref_out !== 1'b0) begin
                bad++;
                $display("FAIL R1 reset ref_out=%0b expected=0", ref_out);
            end
        end else if (ref_out !== m_out) begin
            bad++;
            $display("FAIL %s ref_out=%0b expected=%0b t=%0t", cur_req, ref_out, m_out, $time);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(input logic [7:0] v);
        cfg_we = 1'b1; cfg_wdata = v;
        cyc(1);
        cfg_we = 1'b0;
    endtask

    task automatic vd(input int gap, input logic msk);
        vd_pulse = 1'b1; vd_mask = msk;
        cyc(1);
        vd_pulse = 1'b0; vd_mask = 1'b0;
        cyc(gap);
    endtask

    task automatic trig(input int gap);
        ext_trig = 1'b1;
        cyc(1);
        ext_trig = 1'b0;
        cyc(gap);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cur_req = "R1";
        cyc(4);
        rst_n = 1'b1;
        half_period = 5;
        cur_req = "R2";
        cyc(40);
        vd_pulse = 1'b1; ext_trig = 1'b1;   // ignored in free-run
        cyc(3);
        vd_pulse = 1'b0; ext_trig = 1'b0;
        cur_req = "R11";
        cyc(2);
        half_period = 3;
        cyc(30);
        cur_req = "R3";
        wr_cfg(8'h10);
        cyc(5);
        trig(2); trig(7); trig(0); trig(11);
        cur_req = "R11";
        wr_cfg(8'h00);
        cyc(12);
        cur_req = "R8";
        half_period = 5;
        wr_cfg(8'h20);
        rec_mode = 1'b1;
        cyc(3);
        cur_req = "R4";
        vd(3, 0); vd(3, 0); vd(2, 0); vd(4, 0);
        cur_req = "R5";
        cyc(23);
        cur_req = "R6";
        vd(1, 1); vd(2, 1); vd(1, 0); vd(2, 1); vd(6, 0);
        cur_req = "R7";
        wr_cfg(8'h00);
        vd(2, 0); vd(3, 0); cyc(8);
        wr_cfg(8'h40);
        vd(2, 0); vd(3, 0);
        vnoise = 1'b1;
        vd(2, 0); vd(3, 0); cyc(6);
        vnoise = 1'b0;
        vd(3, 0); cyc(4);
        cur_req = "R9";
        wr_cfg(8'h28);
        field = 1'b0; vd(3, 0); vd(3, 0);
        field = 1'b1; vd(3, 0); vd(8, 0);
        wr_cfg(8'h2C);
        field = 1'b1; vd(3, 0);
        field = 1'b0; vd(3, 0); vd(3, 0);
        cur_req = "R10";
        half_period = 0;
        vd(3, 0); cyc(5);
        half_period = 4;
        cyc(12);
        cur_req = "R8";
        rec_mode = 1'b0;
        cyc(6);
        rec_mode = 1'b1;
        cyc(12);
        rec_mode = 1'b0;
        wr_cfg(8'h10);
        trig(2);
        rec_mode = 1'b1;
        cyc(10);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule